// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Control

This block decides, every minor cycle, whether the next decoded instruction may be handed to one of ten functional units of a processor with three register files (eight 60-bit X, eight 18-bit A, eight 18-bit B registers). It holds a per-unit record of the operation in flight. This record covers the destination register, the source registers, the unit that will produce each source that is not yet available, and whether each source is ready. A per-register table names the unit that will produce each pending result.

Issue stops only for two reasons: the target unit is occupied, or the destination register already has a result on the way. Every other hazard is settled after issue, inside the unit's record. A unit whose sources are not yet written waits before starting. A finished unit whose destination is still needed, in its old value, by an earlier reader waits before writing back. Functional units are modelled as fixed-latency counters. The block drives a start pulse when a unit takes its operands, a write-back grant when it may store its result, and a pending bit for every register.

Top module: `sb_issue_ctrl`

## Requirements
- R1: An instruction is accepted (`in_ready` high while `in_valid`) only when its unit is idle; a unit becomes idle in the cycle after its write-back grant.
- R2: An instruction is held while another in-flight instruction will write its destination register. An instruction whose destination is B0 reserves nothing.
- R3: With neither restriction present, one instruction is accepted in every cycle.
- R4: A source register with a pending result makes the unit wait, not the issue. The unit's start pulse comes one cycle after the producing unit's write-back grant. Later independent instructions keep issuing meanwhile.
- R5: A unit's write-back request comes a fixed number of cycles after its start pulse. By default this is 2 for increment, 4 for floating add, 3 for fixed add, 2 for shift, 10 for multiply, 29 for divide, 1 for boolean and 1 for branch. An unopposed request is granted in the same cycle.
- R6: A write-back is withheld while any earlier-issued unit has a ready but not yet started source equal to the writer's destination. It is granted no earlier than the cycle after that reader's start pulse.
- R7: When several eligible units request write-back in one cycle, only the lowest-numbered unit is granted. The others retry. Unit numbers are: 0,1 increment, 2 floating add, 3 fixed add, 4 shift, 5,6 multiply, 7 divide, 8 boolean, 9 branch.
- R8: With `in_long` set, the k field names no register and never causes a wait. A source of B0 never waits.
- R9: `reg_pending` bit n is high from the cycle after issue to the write-back grant for the register with index n. The index is 0-7 for X0-X7, 8-15 for A0-A7 and 16-23 for B0-B7.
- R10: After reset, no unit is busy, `unit_start`, `unit_wb` and `reg_pending` are all zero, and any instruction is accepted.
- R11: Multiply and increment operations go to the lower-numbered unit of their pair when it is idle, else to the upper one.
- R12: A source whose producer is granted write-back in the issue cycle is taken as ready.
- R13: The opcode's upper three bits select the operation class: 0 branch (reads X j, X k, no result), 1 boolean, 2 shift, 3 floating add, 4 multiply, 5 divide, 6 fixed add (all X i from X j, X k), 7 increment. For increment, the result is A i, B i or X i for opcode bits [1:0] = 0, 1 or other, and the sources are A j and B k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | 6 | Operation code |
| in_i | input | 3 | Result register number |
| in_j | input | 3 | First source register number |
| in_k | input | 3 | Second source register number |
| in_long | input | 1 | Long format: k field is a constant |
| unit_start | output | 10 | Per-unit pulse: operands taken, execution begins |
| unit_wb | output | 10 | Per-unit write-back grant |
| reg_pending | output | 24 | Per-register result-pending flags |

## Verification
The hardest situation to reach is a write-after-read hold. It needs a writer that finishes while an earlier reader has one source ready and unread, with that reader held up by a different, slow producer. The stimulus reaches it with a divide feeding the reader's first source, then a one-cycle boolean writing the reader's second source. The grant must then track the divide's completion plus one cycle. Same-cycle write-back contention and issue-time forwarding are arranged in the same way, by choosing latencies so that two completions land in one cycle, or by timing a dependent issue to meet its producer's grant.

// File: rtl/sb_pkg.sv
// Shared constants and types for the scoreboard issue controller.
// Assumes three register files of equal depth, indexed file*8+number.
package sb_pkg;
    localparam int NUM_UNITS     = 10;
    localparam int REGS_PER_FILE = 8;
    localparam int NUM_FILES     = 3;
    localparam int NUM_REGS      = NUM_FILES * REGS_PER_FILE;
    localparam int REG_W         = $clog2(NUM_REGS);
    localparam int UNIT_W        = $clog2(NUM_UNITS);
    localparam int RNUM_W        = $clog2(REGS_PER_FILE);

    localparam logic [1:0] FILE_X = 2'd0;
    localparam logic [1:0] FILE_A = 2'd1;
    localparam logic [1:0] FILE_B = 2'd2;
    localparam logic [REG_W-1:0] REG_B0 = {FILE_B, {RNUM_W{1'b0}}};

    // Unit numbering also sets write-back priority (lower wins).
    typedef enum logic [UNIT_W-1:0] {
        U_INC0, U_INC1, U_FADD, U_IADD, U_SHIFT,
        U_MUL0, U_MUL1, U_DIV, U_BOOL, U_BRANCH
    } unit_e;

    // Operation class, equal to the upper opcode digit.
    typedef enum logic [2:0] {
        C_BRANCH, C_BOOL, C_SHIFT, C_FADD, C_MUL, C_DIV, C_IADD, C_INC
    } class_e;

    typedef struct packed {
        class_e           cls;
        logic             has_dest;
        logic [REG_W-1:0] dest;
        logic             has_j;
        logic [REG_W-1:0] src_j;
        logic             has_k;
        logic [REG_W-1:0] src_k;
    } dec_t;
endpackage

// File: rtl/sb_decode.sv
// Instruction decoder: maps opcode and register fields to a class and
// flat register indices. Assumes B0 is constant zero, so it is never a
// real source and never a reserved destination.
module sb_decode
    import sb_pkg::*;
(
    input  logic [5:0]        op,
    input  logic [RNUM_W-1:0] fi,
    input  logic [RNUM_W-1:0] fj,
    input  logic [RNUM_W-1:0] fk,
    input  logic              is_long,
    output dec_t              dec
);
    // Field decode, file selection and B0 filtering.
    always_comb begin
        dec          = '0;
        dec.cls      = class_e'(op[5:3]);
        dec.has_dest = (dec.cls != C_BRANCH);
        dec.dest     = {FILE_X, fi};
        dec.has_j    = 1'b1;
        dec.src_j    = {FILE_X, fj};
        dec.has_k    = !is_long;
        dec.src_k    = {FILE_X, fk};
        if (dec.cls == C_INC) begin
            case (op[1:0])
                2'd0:    dec.dest = {FILE_A, fi};
                2'd1:    dec.dest = {FILE_B, fi};
                default: dec.dest = {FILE_X, fi};
            endcase
            dec.src_j = {FILE_A, fj};
            dec.src_k = {FILE_B, fk};
        end
        if (dec.dest  == REG_B0) dec.has_dest = 1'b0;
        if (dec.src_j == REG_B0) dec.has_j    = 1'b0;
        if (dec.src_k == REG_B0) dec.has_k    = 1'b0;
    end
endmodule

// File: rtl/sb_slot.sv
// One functional-unit record: holds the issued operation, waits for its
// sources, counts a fixed latency, then requests write-back until granted.
// Assumes issue only arrives while idle and grant only while requesting.
module sb_slot
    import sb_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic                 i_has_dest,
    input  logic [REG_W-1:0]     i_dest,
    input  logic                 i_has_j,
    input  logic [REG_W-1:0]     i_src_j,
    input  logic                 i_wait_j,
    input  logic [UNIT_W-1:0]    i_prod_j,
    input  logic                 i_has_k,
    input  logic [REG_W-1:0]     i_src_k,
    input  logic                 i_wait_k,
    input  logic [UNIT_W-1:0]    i_prod_k,
    input  logic [NUM_UNITS-1:0] wb_vec,
    input  logic                 grant,
    output logic                 busy,
    output logic                 start,
    output logic                 wb_req,
    output logic                 has_dest,
    output logic [REG_W-1:0]     dest,
    output logic                 unread_j,
    output logic [REG_W-1:0]     src_j,
    output logic                 unread_k,
    output logic [REG_W-1:0]     src_k
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic              read_done, has_j, has_k, rdy_j, rdy_k;
    logic [UNIT_W-1:0] prod_j, prod_k;
    logic [CNT_W-1:0]  cnt;

    assign start    = busy && !read_done && rdy_j && rdy_k;
    assign wb_req   = busy && read_done && (cnt == '0);
    assign unread_j = busy && !read_done && has_j && rdy_j;
    assign unread_k = busy && !read_done && has_k && rdy_k;

    // Record life cycle: capture on issue, wake sources, count, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            read_done <= 1'b0;
            has_dest  <= 1'b0;
            dest      <= '0;
            has_j     <= 1'b0;
            has_k     <= 1'b0;
            src_j     <= '0;
            src_k     <= '0;
            rdy_j     <= 1'b0;
            rdy_k     <= 1'b0;
            prod_j    <= '0;
            prod_k    <= '0;
            cnt       <= '0;
        end else if (issue) begin
            busy      <= 1'b1;
            read_done <= 1'b0;
            has_dest  <= i_has_dest;
            dest      <= i_dest;
            has_j     <= i_has_j;
            has_k     <= i_has_k;
            src_j     <= i_src_j;
            src_k     <= i_src_k;
            rdy_j     <= !i_wait_j;
            rdy_k     <= !i_wait_k;
            prod_j    <= i_prod_j;
            prod_k    <= i_prod_k;
        end else if (grant) begin
            busy      <= 1'b0;
            read_done <= 1'b0;
        end else begin
            if (start) begin
                read_done <= 1'b1;
                cnt       <= CNT_W'(LAT - 1);
            end else if (read_done && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (busy && !rdy_j && wb_vec[prod_j]) rdy_j <= 1'b1;
            if (busy && !rdy_k && wb_vec[prod_k]) rdy_k <= 1'b1;
        end
    end

    // R1: a record only becomes busy through an issue.
    a_r1_busy_from_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(issue));
    // R1: the unit is idle again right after its grant.
    a_r1_idle_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !busy);
    // R5: a grant only reaches a unit that has finished counting.
    a_r5_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> wb_req);
endmodule

// File: rtl/sb_wb_arb.sv
// Fixed-priority write-back arbiter: grants the lowest-numbered request.
// Assumes requests are already filtered for read-before-write hazards.
module sb_wb_arb #(
    parameter int N = 10
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic found;

    // Scan upward; the first request wins.
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int n = 0; n < N; n++) begin
            if (req[n] && !found) begin
                gnt[n] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Scoreboard issue controller: decodes an instruction, picks a unit,
// accepts it when the unit is idle and its result register is free, and
// arbitrates write-back against pending earlier readers.
// Assumes one instruction offered per cycle and fixed unit latencies.
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int LAT_INC    = 2,
    parameter int LAT_FADD   = 4,
    parameter int LAT_IADD   = 3,
    parameter int LAT_SHIFT  = 2,
    parameter int LAT_MUL    = 10,
    parameter int LAT_DIV    = 29,
    parameter int LAT_BOOL   = 1,
    parameter int LAT_BRANCH = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [5:0]           in_op,
    input  logic [2:0]           in_i,
    input  logic [2:0]           in_j,
    input  logic [2:0]           in_k,
    input  logic                 in_long,
    output logic [9:0]           unit_start,
    output logic [9:0]           unit_wb,
    output logic [23:0]          reg_pending
);
    localparam int LAT_TABLE [NUM_UNITS] = '{LAT_INC, LAT_INC, LAT_FADD,
        LAT_IADD, LAT_SHIFT, LAT_MUL, LAT_MUL, LAT_DIV, LAT_BOOL, LAT_BRANCH};

    dec_t                 dec;
    unit_e                sel;
    logic                 do_issue, wait_j, wait_k;
    logic [NUM_UNITS-1:0] issue_vec, s_busy, s_req, s_hd, s_unj, s_unk, eligible;
    logic [REG_W-1:0]     s_dest [NUM_UNITS];
    logic [REG_W-1:0]     s_srcj [NUM_UNITS];
    logic [REG_W-1:0]     s_srck [NUM_UNITS];
    logic [NUM_REGS-1:0]  prod_v;
    logic [UNIT_W-1:0]    prod_u [NUM_REGS];

    sb_decode i_dec (
        .op(in_op), .fi(in_i), .fj(in_j), .fk(in_k), .is_long(in_long), .dec(dec)
    );

    // Unit choice: paired classes take the lower unit when it is idle.
    always_comb begin
        case (dec.cls)
            C_BRANCH: sel = U_BRANCH;
            C_BOOL:   sel = U_BOOL;
            C_SHIFT:  sel = U_SHIFT;
            C_FADD:   sel = U_FADD;
            C_DIV:    sel = U_DIV;
            C_IADD:   sel = U_IADD;
            C_MUL:    sel = s_busy[U_MUL0] ? U_MUL1 : U_MUL0;
            default:  sel = s_busy[U_INC0] ? U_INC1 : U_INC0;
        endcase
    end

    // Issue gate and one-hot issue vector.
    always_comb begin
        in_ready = !s_busy[sel] && !(dec.has_dest && prod_v[dec.dest]);
        do_issue = in_valid && in_ready;
        for (int u = 0; u < NUM_UNITS; u++)
            issue_vec[u] = do_issue && (sel == unit_e'(u));
    end

    // Source wait flags, taking a same-cycle grant as already written.
    assign wait_j = dec.has_j && prod_v[dec.src_j] && !unit_wb[prod_u[dec.src_j]];
    assign wait_k = dec.has_k && prod_v[dec.src_k] && !unit_wb[prod_u[dec.src_k]];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
        sb_slot #(.LAT(LAT_TABLE[u])) i_slot (
            .clk(clk), .rst_n(rst_n), .issue(issue_vec[u]),
            .i_has_dest(dec.has_dest), .i_dest(dec.dest),
            .i_has_j(dec.has_j), .i_src_j(dec.src_j), .i_wait_j(wait_j),
            .i_prod_j(prod_u[dec.src_j]),
            .i_has_k(dec.has_k), .i_src_k(dec.src_k), .i_wait_k(wait_k),
            .i_prod_k(prod_u[dec.src_k]),
            .wb_vec(unit_wb), .grant(unit_wb[u]),
            .busy(s_busy[u]), .start(unit_start[u]), .wb_req(s_req[u]),
            .has_dest(s_hd[u]), .dest(s_dest[u]),
            .unread_j(s_unj[u]), .src_j(s_srcj[u]),
            .unread_k(s_unk[u]), .src_k(s_srck[u])
        );
    end

    // Read-before-write filter: hold a writer while an older reader is unread.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            eligible[u] = s_req[u];
            for (int v = 0; v < NUM_UNITS; v++) begin
                if (s_hd[u] && s_unj[v] && s_srcj[v] == s_dest[u]) eligible[u] = 1'b0;
                if (s_hd[u] && s_unk[v] && s_srck[v] == s_dest[u]) eligible[u] = 1'b0;
            end
        end
    end

    sb_wb_arb #(.N(NUM_UNITS)) i_arb (.req(eligible), .gnt(unit_wb));

    // Result table: release on write-back, reserve on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_v <= '0;
            for (int r = 0; r < NUM_REGS; r++) prod_u[r] <= '0;
        end else begin
            for (int u = 0; u < NUM_UNITS; u++)
                if (unit_wb[u] && s_hd[u]) prod_v[s_dest[u]] <= 1'b0;
            if (do_issue && dec.has_dest) begin
                prod_v[dec.dest] <= 1'b1;
                prod_u[dec.dest] <= UNIT_W'(sel);
            end
        end
    end

    assign reg_pending = prod_v;

    // R7: at most one write-back per cycle.
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_wb));
    // R9: an accepted result register shows pending in the next cycle.
    a_r9_reserve_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (do_issue && dec.has_dest) |=> reg_pending[$past(dec.dest)]);

    // R2 and R6: no two records share a result; no grant overtakes a reader.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                for (int v = 0; v < NUM_UNITS; v++) begin
                    if (u != v && s_busy[u] && s_busy[v] && s_hd[u] && s_hd[v])
                        a_r2_unique_dest: assert (s_dest[u] != s_dest[v]);
                    if (unit_wb[u] && s_hd[u])
                        a_r6_no_early_write: assert (!(s_unj[v] && s_srcj[v] == s_dest[u])
                                                  && !(s_unk[v] && s_srck[v] == s_dest[u]));
                end
            end
        end
    end
endmodule

// File: tb/test_sb_issue_ctrl.sv
module test_sb_issue_ctrl;
    localparam int CLK_PERIOD = 10;

    // Unit numbers and latencies as stated in R5 and R7.
    localparam int INC0 = 0, INC1 = 1, FADD = 2, IADD = 3, SHIFT = 4;
    localparam int MUL0 = 5, MUL1 = 6, DIV = 7, BOOL = 8, BR = 9;
    localparam int L_INC = 2, L_FADD = 4, L_IADD = 3, L_SHIFT = 2;
    localparam int L_MUL = 10, L_DIV = 29, L_BOOL = 1, L_BR = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_op = '0;
    logic [2:0]  in_i = '0, in_j = '0, in_k = '0;
    logic        in_long = 1'b0;
    logic [9:0]  unit_start, unit_wb;
    logic [23:0] reg_pending;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;

    typedef struct {
        bit    is_wb;
        int    unit;
        int    at;
        string tag;
    } ev_t;
    ev_t exp_q[$];

    sb_issue_ctrl i_sb_issue_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_i(in_i), .in_j(in_j), .in_k(in_k), .in_long(in_long),
        .unit_start(unit_start), .unit_wb(unit_wb), .reg_pending(reg_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input bit is_wb, input int unit, input int at, input string tag);
        ev_t e;
        e.is_wb = is_wb; e.unit = unit; e.at = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor side: pop the matching expected event and compare its cycle.
    task automatic match_ev(input bit is_wb, input int unit);
        for (int n = 0; n < exp_q.size(); n++) begin
            if (exp_q[n].is_wb == is_wb && exp_q[n].unit == unit) begin
                chk(exp_q[n].at == cyc, exp_q[n].tag, cyc, exp_q[n].at);
                exp_q.delete(n);
                return;
            end
        end
        chk(1'b0, is_wb ? "unexpected write-back (R5)" : "unexpected start (R4)", unit, -1);
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            for (int u = 0; u < 10; u++) begin
                if (unit_start[u]) match_ev(1'b0, u);
                if (unit_wb[u])    match_ev(1'b1, u);
            end
        end
    end

    // Driver side: offer an instruction until accepted; return its cycle.
    task automatic issue(input int f, input int m, input int i, input int j,
                         input int k, input bit lng, output int w);
        @(negedge clk);
        in_valid = 1'b1;
        in_op = {3'(f), 3'(m)};
        in_i = 3'(i); in_j = 3'(j); in_k = 3'(k); in_long = lng;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        w = cyc;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain(input int n, input string tag);
        repeat (n) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic at_cycle(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0, w1, w2, w3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet outputs after reset, any instruction acceptable.
        chk(unit_start == '0, "R10 start idle", unit_start, 0);
        chk(unit_wb == '0, "R10 wb idle", unit_wb, 0);
        chk(reg_pending == '0, "R10 no pending", reg_pending, 0);
        in_op = 6'o50;
        #1 chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
        mon_on = 1'b1;

        // R3 / R13: three independent classes issue back to back.
        issue(6, 0, 1, 2, 3, 0, w0);
        expect_ev(0, IADD, w0 + 1, "R13 fixed add start");
        expect_ev(1, IADD, w0 + 1 + L_IADD, "R5 fixed add latency");
        issue(0, 0, 0, 4, 5, 0, w1);
        expect_ev(0, BR, w1 + 1, "R13 branch start");
        expect_ev(1, BR, w1 + 1 + L_BR, "R5 branch latency");
        issue(2, 0, 6, 7, 0, 0, w2);
        expect_ev(0, SHIFT, w2 + 1, "R13 shift start");
        expect_ev(1, SHIFT, w2 + 1 + L_SHIFT, "R5 shift latency");
        chk(w1 == w0 + 1, "R3 second issue next cycle", w1, w0 + 1);
        chk(w2 == w0 + 2, "R3 third issue next cycle", w2, w0 + 2);
        drain(12, "R3 events complete");

        // R4 / R7: dependent waits in unit; boolean loses tie to fixed add.
        issue(6, 0, 1, 2, 3, 0, w0);
        expect_ev(0, IADD, w0 + 1, "R4 producer start");
        expect_ev(1, IADD, w0 + 4, "R7 lower unit wins tie");
        issue(3, 0, 5, 1, 2, 0, w1);
        chk(w1 == w0 + 1, "R4 dependent not stalled", w1, w0 + 1);
        expect_ev(0, FADD, w0 + 5, "R4 start after producer grant");
        expect_ev(1, FADD, w0 + 5 + L_FADD, "R5 floating add latency");
        issue(1, 0, 6, 7, 7, 0, w2);
        chk(w2 == w0 + 2, "R4 independent keeps issuing", w2, w0 + 2);
        expect_ev(0, BOOL, w0 + 3, "R4 independent start");
        expect_ev(1, BOOL, w0 + 5, "R7 higher unit retries");
        drain(15, "R4 events complete");

        // R1 / R5: second divide waits for the first to finish.
        issue(5, 0, 1, 2, 3, 0, w0);
        expect_ev(0, DIV, w0 + 1, "R1 first divide start");
        expect_ev(1, DIV, w0 + 1 + L_DIV, "R5 divide latency");
        issue(5, 0, 4, 5, 6, 0, w1);
        chk(w1 == w0 + 2 + L_DIV, "R1 divide held while busy", w1, w0 + 2 + L_DIV);
        expect_ev(0, DIV, w1 + 1, "R1 second divide start");
        expect_ev(1, DIV, w1 + 1 + L_DIV, "R5 second divide latency");
        drain(40, "R1 events complete");

        // R11 / R1: multiplies fill both units then the third waits.
        issue(4, 0, 1, 4, 5, 0, w0);
        expect_ev(0, MUL0, w0 + 1, "R11 first multiply lower unit");
        expect_ev(1, MUL0, w0 + 1 + L_MUL, "R5 multiply latency");
        issue(4, 0, 2, 4, 5, 0, w1);
        expect_ev(0, MUL1, w1 + 1, "R11 second multiply upper unit");
        expect_ev(1, MUL1, w1 + 1 + L_MUL, "R5 upper multiply latency");
        issue(4, 0, 3, 4, 5, 0, w2);
        chk(w2 == w0 + 2 + L_MUL, "R1 third multiply waits", w2, w0 + 2 + L_MUL);
        expect_ev(0, MUL0, w2 + 1, "R11 third multiply reuses lower");
        expect_ev(1, MUL0, w2 + 1 + L_MUL, "R5 third multiply latency");
        drain(20, "R11 events complete");

        // R2: second writer of X1 held until the first one's grant.
        issue(6, 0, 1, 2, 3, 0, w0);
        expect_ev(0, IADD, w0 + 1, "R2 first writer start");
        expect_ev(1, IADD, w0 + 4, "R2 first writer wb");
        issue(3, 0, 1, 4, 5, 0, w1);
        chk(w1 == w0 + 5, "R2 same destination held", w1, w0 + 5);
        expect_ev(0, FADD, w1 + 1, "R2 second writer start");
        expect_ev(1, FADD, w1 + 1 + L_FADD, "R2 second writer wb");
        drain(12, "R2 events complete");

        // R6 / R9: boolean write of X3 held until the reader takes X3.
        issue(5, 0, 1, 2, 3, 0, w0);
        expect_ev(0, DIV, w0 + 1, "R6 divide start");
        expect_ev(1, DIV, w0 + 30, "R6 divide wb");
        issue(3, 0, 2, 1, 3, 0, w1);
        expect_ev(0, FADD, w0 + 31, "R6 reader start");
        expect_ev(1, FADD, w0 + 35, "R6 reader wb");
        issue(1, 0, 3, 4, 4, 0, w2);
        chk(w2 == w0 + 2, "R6 writer issues freely", w2, w0 + 2);
        expect_ev(0, BOOL, w0 + 3, "R6 writer start");
        expect_ev(1, BOOL, w0 + 32, "R6 write held past reader start");
        at_cycle(w0 + 5);
        chk(reg_pending == 24'h00000E, "R9 X1 X2 X3 pending", reg_pending, 24'h00000E);
        drain(40, "R6 events complete");

        // R2 / R8 / R11 / R12: increments with B0 and same-cycle forwarding.
        issue(7, 1, 0, 1, 1, 0, w0);
        expect_ev(0, INC0, w0 + 1, "R11 increment lower unit");
        expect_ev(1, INC0, w0 + 1 + L_INC, "R5 increment latency");
        issue(7, 1, 2, 2, 0, 0, w1);
        expect_ev(0, INC1, w1 + 1, "R8 B0 source never waits");
        expect_ev(1, INC1, w1 + 1 + L_INC, "R5 upper increment latency");
        chk(w1 == w0 + 1, "R2 B0 result reserves nothing", w1, w0 + 1);
        at_cycle(w0 + 2);
        chk(reg_pending == 24'h040000, "R9 only B2 pending", reg_pending, 24'h040000);
        issue(7, 0, 3, 1, 2, 0, w2);
        chk(w2 == w0 + 4, "R12 issue meets producer grant", w2, w0 + 4);
        expect_ev(0, INC0, w2 + 1, "R12 forwarded source ready");
        expect_ev(1, INC0, w2 + 1 + L_INC, "R5 forwarded increment latency");
        drain(10, "R12 events complete");

        // R8: long format ignores a pending register named by k.
        issue(5, 0, 2, 3, 4, 0, w0);
        expect_ev(0, DIV, w0 + 1, "R8 divide start");
        expect_ev(1, DIV, w0 + 30, "R8 divide wb");
        issue(3, 0, 5, 1, 2, 1, w3);
        expect_ev(0, FADD, w3 + 1, "R8 long format k ignored");
        expect_ev(1, FADD, w3 + 1 + L_FADD, "R8 long format wb");
        drain(40, "R8 events complete");

        mon_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule